// File: doc/BRIEF.md
# Banked Memory Mapper with Status Port

This block sits between an 8-bit CPU and its memories. The CPU sees a 64 KB address space. The block steers each memory access to one of four 64 KB RAM banks, a 2 KB battery-backed CMOS store, an 8 KB boot ROM, or an open region that reads as 0xFF and ignores writes. The routing decision depends on 2 KB pages, which are address bits 15:11. The offset inside a page is bits 10:0. The block also decodes a small set of 8-bit I/O ports. These ports load the bank register and the two mode flags, read back a status byte that merges the bank nibble with live floppy sideband lines, read an inverted DIP-switch byte, and control a speaker enable.

The routing mode is a three-state machine:

- **BOOT**: the ROM overlays the low memory.
- **FULL**: the whole banked region goes to the selected RAM bank.
- **WINDOW**: like FULL, except that one page is given to the CMOS store.

The machine moves between states through these named transitions:

- **OVERLAY_ON**: any state goes to BOOT on an overlay-port write with bit 0 = 1.
- **OVERLAY_OFF**: BOOT goes to WINDOW if the window flag is set, otherwise to FULL, on an overlay-port write with bit 0 = 0.
- **WIN_ON**: FULL goes to WINDOW on a window-port write with bit 0 = 1.
- **WIN_OFF**: WINDOW goes to FULL on a window-port write with bit 0 = 0.
- A window-port write made while in BOOT only records the flag.

The block drives chip selects, write enables and addresses to external synchronous-read memories. It returns their data, or 0xFF, on the CPU read bus one cycle after the read strobe.

Top module: `memmap_ctrl`

## Requirements
- R1: After reset the mode is BOOT, the bank nibble is 0, the window flag is 0, the speaker flag is 0 and `spk_en` is 0.
- R2: In BOOT, reads of 0x0000–0x1FFF come from the ROM with `rom_addr` = address bits 12:0. Reads of 0x2000–0xDFFF return 0xFF. Writes below 0xE000 reach no store.
- R3: Accesses to 0xE000–0xFFFF go to RAM at `ram_addr` = {2'b00, address} in every mode and with every bank value.
- R4: In FULL, accesses to 0x0000–0xDFFF go to RAM at `ram_addr` = {bank index, address}.
- R5: The bank index comes from bank nibble bits by priority. Bit 0 (data bit 4 when loaded) selects index 0, then bit 1 selects index 1, bit 2 selects index 2 and bit 3 selects index 3. The lowest set bit wins.
- R6: With a bank nibble of 0, banked-region reads return 0xFF and banked-region writes are dropped. In WINDOW the CMOS page is still served.
- R7: In WINDOW, page 0x8000–0x87FF is the CMOS store (read and write, `cmos_addr` = address bits 10:0). The rest of 0x0000–0xDFFF behaves as in FULL. At most one of `ram_cs`, `rom_cs`, `cmos_cs` is high.
- R8: An I/O write to 0x30–0x33 loads the bank nibble from data bits 7:4. A write to 0x1C–0x1F sets the overlay flag from data bit 0. A write to 0x20–0x23 sets the window flag from data bit 0. BOOT takes precedence over the window flag.
- R9: `mem_rdata` and `io_rdata` carry the read result in the cycle after the cycle in which the strobe is sampled.
- R10: An I/O read of 0x30–0x33 returns {bank nibble, disk_present, 0, ~motor_on, fdc_irq} in bits 7..0.
- R11: An I/O read of 0x18–0x1B returns the bitwise inverse of `dip_sw`.
- R12: An I/O write to 0x18–0x1B sets the speaker flag from data bit 2 only. `spk_en` equals (speaker flag OR `timer_out`) as sampled one clock earlier.
- R13: I/O reads of undecoded ports return 0xFF. I/O writes to undecoded ports change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | input | 16 | CPU memory address |
| mem_wdata | input | 8 | CPU memory write data |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| mem_rdata | output | 8 | Memory read data, cycle after strobe |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_rdata | output | 8 | I/O read data, cycle after strobe |
| dip_sw | input | 8 | DIP-switch byte |
| disk_present | input | 1 | Disk inserted |
| motor_on | input | 1 | Drive motor running |
| fdc_irq | input | 1 | Floppy controller interrupt |
| timer_out | input | 1 | External timer tone output |
| spk_en | output | 1 | Speaker enable |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 18 | RAM address {bank, offset} |
| ram_rdata | input | 8 | RAM read data (synchronous) |
| rom_cs | output | 1 | ROM select |
| rom_addr | output | 13 | ROM address |
| rom_rdata | input | 8 | ROM read data (synchronous) |
| cmos_cs | output | 1 | CMOS select |
| cmos_we | output | 1 | CMOS write enable |
| cmos_addr | output | 11 | CMOS address |
| cmos_rdata | input | 8 | CMOS read data (synchronous) |
| st_wdata | output | 8 | Write data to all stores |

## Verification
The hardest situation to reach is one where a write must be shown to have gone nowhere. Examples are a write made in BOOT, or a write made with an empty bank nibble. Only a later read through a different mapping can expose such a write. The stimulus therefore writes to 0x1000 under those conditions. It then switches to FULL with a real bank selected and reads back the untouched value. It also leaves WINDOW by re-entering BOOT and then exits BOOT again, to prove that the stored window flag brings back CMOS routing rather than FULL.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int PAGE_W     = 11;
    localparam int NUM_BANKS  = 4;
    localparam int BANK_IDX_W = $clog2(NUM_BANKS);
    localparam int RAM_AW     = ADDR_W + BANK_IDX_W;
    localparam int ROM_AW     = 13;
    localparam int PG_W       = ADDR_W - PAGE_W;

    // page numbers (address bits 15:11)
    localparam logic [PG_W-1:0] PG_ROM_LAST  = PG_W'(((1 << ROM_AW) >> PAGE_W) - 1);
    localparam logic [PG_W-1:0] PG_BANK_LAST = 5'h1B;
    localparam logic [PG_W-1:0] PG_CMOS      = 5'h10;

    // I/O port groups (address bits 7:2)
    localparam logic [5:0] PORT_SPK  = 6'h06;
    localparam logic [5:0] PORT_OVL  = 6'h07;
    localparam logic [5:0] PORT_WIN  = 6'h08;
    localparam logic [5:0] PORT_STAT = 6'h0C;

    typedef enum logic [1:0] {
        MODE_BOOT   = 2'd0,
        MODE_FULL   = 2'd1,
        MODE_WINDOW = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        TGT_OPEN = 2'd0,
        TGT_RAM  = 2'd1,
        TGT_ROM  = 2'd2,
        TGT_CMOS = 2'd3
    } tgt_e;
endpackage

// File: rtl/memmap_mode_fsm.sv
module memmap_mode_fsm
    import memmap_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ovl_wr,
    input  logic  win_wr,
    input  logic  wbit,
    output mode_e mode,
    output logic  win_flag
);
    mode_e state_q, state_d;
    logic  win_q, win_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_BOOT;
            win_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            win_q   <= win_d;
        end
    end

    always_comb begin
        state_d = state_q;
        win_d   = win_q;
        if (win_wr) win_d = wbit;
        unique case (state_q)
            MODE_BOOT: begin
                if (ovl_wr && !wbit)
                    state_d = win_q ? MODE_WINDOW : MODE_FULL;   // OVERLAY_OFF
            end
            MODE_FULL: begin
                if (ovl_wr && wbit)      state_d = MODE_BOOT;    // OVERLAY_ON
                else if (win_wr && wbit) state_d = MODE_WINDOW;  // WIN_ON
            end
            MODE_WINDOW: begin
                if (ovl_wr && wbit)       state_d = MODE_BOOT;   // OVERLAY_ON
                else if (win_wr && !wbit) state_d = MODE_FULL;   // WIN_OFF
            end
            default: state_d = MODE_BOOT;
        endcase
    end

    always_comb begin
        mode     = state_q;
        win_flag = win_q;
    end
endmodule

// File: rtl/memmap_bank_sel.sv
module memmap_bank_sel #(
    parameter int NB    = 4,
    parameter int IDX_W = $clog2(NB)
) (
    input  logic [NB-1:0]    sel_bits,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    // lowest set bit wins
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (sel_bits[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/memmap_page_decode.sv
module memmap_page_decode
    import memmap_pkg::*;
(
    input  mode_e                   mode,
    input  logic                    bank_valid,
    input  logic [BANK_IDX_W-1:0]   bank_idx,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    rd,
    input  logic                    wr,
    output tgt_e                    tgt,
    output logic                    ram_cs,
    output logic                    ram_we,
    output logic [RAM_AW-1:0]       ram_addr,
    output logic                    rom_cs,
    output logic [ROM_AW-1:0]       rom_addr,
    output logic                    cmos_cs,
    output logic                    cmos_we,
    output logic [PAGE_W-1:0]       cmos_addr
);
    logic [PG_W-1:0] page;
    logic            use_bank;

    always_comb begin
        page     = addr[ADDR_W-1:PAGE_W];
        tgt      = TGT_OPEN;
        use_bank = 1'b0;
        ram_addr = {{BANK_IDX_W{1'b0}}, addr};
        if (page > PG_BANK_LAST) begin
            tgt = TGT_RAM;
        end else begin
            unique case (mode)
                MODE_BOOT:   tgt = (page <= PG_ROM_LAST) ? TGT_ROM : TGT_OPEN;
                MODE_WINDOW: begin
                    if (page == PG_CMOS) tgt = TGT_CMOS;
                    else                 use_bank = 1'b1;
                end
                MODE_FULL:   use_bank = 1'b1;
                default:     tgt = TGT_OPEN;
            endcase
            if (use_bank && bank_valid) begin
                tgt      = TGT_RAM;
                ram_addr = {bank_idx, addr};
            end
        end
    end

    always_comb begin
        ram_cs    = (rd || wr) && (tgt == TGT_RAM);
        ram_we    = wr && (tgt == TGT_RAM);
        rom_cs    = rd && (tgt == TGT_ROM);
        rom_addr  = addr[ROM_AW-1:0];
        cmos_cs   = (rd || wr) && (tgt == TGT_CMOS);
        cmos_we   = wr && (tgt == TGT_CMOS);
        cmos_addr = addr[PAGE_W-1:0];
    end
endmodule

// File: rtl/memmap_io_regs.sv
module memmap_io_regs
    import memmap_pkg::*;
#(
    parameter int NB = NUM_BANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] dip_sw,
    input  logic              disk_present,
    input  logic              motor_on,
    input  logic              fdc_irq,
    input  logic              timer_out,
    output logic [NB-1:0]     bank_nib,
    output logic              ovl_wr,
    output logic              win_wr,
    output logic              wbit,
    output logic              spk_flag,
    output logic              spk_en,
    output logic [DATA_W-1:0] io_rdata
);
    logic [5:0]        grp;
    logic [NB-1:0]     bank_q;
    logic              spk_q, spk_out_q;
    logic [DATA_W-1:0] rd_q, rd_d;
    logic              unused_bits;

    assign grp         = io_addr[7:2];
    assign unused_bits = ^{io_wdata[3], io_wdata[1]};

    always_comb begin
        ovl_wr = io_wr && (grp == PORT_OVL);
        win_wr = io_wr && (grp == PORT_WIN);
        wbit   = io_wdata[0];
    end

    always_comb begin
        unique case (grp)
            PORT_SPK:  rd_d = ~dip_sw;
            PORT_STAT: rd_d = {bank_q, disk_present, 1'b0, ~motor_on, fdc_irq};
            default:   rd_d = '1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q    <= '0;
            spk_q     <= 1'b0;
            spk_out_q <= 1'b0;
            rd_q      <= '1;
        end else begin
            if (io_wr && grp == PORT_STAT) bank_q <= io_wdata[DATA_W-1 -: NB];
            if (io_wr && grp == PORT_SPK)  spk_q  <= io_wdata[2];
            if (io_rd)                     rd_q   <= rd_d;
            spk_out_q <= spk_q | timer_out;
        end
    end

    assign bank_nib = bank_q;
    assign spk_flag = spk_q;
    assign spk_en   = spk_out_q;
    assign io_rdata = rd_q;
endmodule

// File: rtl/memmap_ctrl.sv
module memmap_ctrl
    import memmap_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   mem_addr,
    input  logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_rd,
    input  logic                mem_wr,
    output logic [DATA_W-1:0]   mem_rdata,
    input  logic [7:0]          io_addr,
    input  logic [DATA_W-1:0]   io_wdata,
    input  logic                io_rd,
    input  logic                io_wr,
    output logic [DATA_W-1:0]   io_rdata,
    input  logic [DATA_W-1:0]   dip_sw,
    input  logic                disk_present,
    input  logic                motor_on,
    input  logic                fdc_irq,
    input  logic                timer_out,
    output logic                spk_en,
    output logic                ram_cs,
    output logic                ram_we,
    output logic [RAM_AW-1:0]   ram_addr,
    input  logic [DATA_W-1:0]   ram_rdata,
    output logic                rom_cs,
    output logic [ROM_AW-1:0]   rom_addr,
    input  logic [DATA_W-1:0]   rom_rdata,
    output logic                cmos_cs,
    output logic                cmos_we,
    output logic [PAGE_W-1:0]   cmos_addr,
    input  logic [DATA_W-1:0]   cmos_rdata,
    output logic [DATA_W-1:0]   st_wdata
);
    logic [NUM_BANKS-1:0]  bank_nib;
    logic                  ovl_wr, win_wr, wbit, spk_flag, win_flag;
    logic                  bank_valid;
    logic [BANK_IDX_W-1:0] bank_idx;
    mode_e                 mode;
    tgt_e                  tgt, src_q;

    memmap_io_regs #(.NB(NUM_BANKS)) u_io (
        .clk(clk), .rst_n(rst_n),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rd(io_rd), .io_wr(io_wr),
        .dip_sw(dip_sw), .disk_present(disk_present), .motor_on(motor_on),
        .fdc_irq(fdc_irq), .timer_out(timer_out),
        .bank_nib(bank_nib), .ovl_wr(ovl_wr), .win_wr(win_wr), .wbit(wbit),
        .spk_flag(spk_flag), .spk_en(spk_en), .io_rdata(io_rdata)
    );

    memmap_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ovl_wr(ovl_wr), .win_wr(win_wr),
        .wbit(wbit), .mode(mode), .win_flag(win_flag)
    );

    memmap_bank_sel #(.NB(NUM_BANKS), .IDX_W(BANK_IDX_W)) u_bank (
        .sel_bits(bank_nib), .valid(bank_valid), .idx(bank_idx)
    );

    memmap_page_decode u_dec (
        .mode(mode), .bank_valid(bank_valid), .bank_idx(bank_idx),
        .addr(mem_addr), .rd(mem_rd), .wr(mem_wr), .tgt(tgt),
        .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr),
        .rom_cs(rom_cs), .rom_addr(rom_addr),
        .cmos_cs(cmos_cs), .cmos_we(cmos_we), .cmos_addr(cmos_addr)
    );

    // return-path source follows the strobe by one clock
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= TGT_OPEN;
        else        src_q <= mem_rd ? tgt : TGT_OPEN;
    end

    always_comb begin
        unique case (src_q)
            TGT_RAM:  mem_rdata = ram_rdata;
            TGT_ROM:  mem_rdata = rom_rdata;
            TGT_CMOS: mem_rdata = cmos_rdata;
            default:  mem_rdata = '1;
        endcase
    end

    assign st_wdata = mem_wdata;
endmodule

// File: rtl/memmap_ctrl_chk.sv
module memmap_ctrl_chk
    import memmap_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic                 mem_rd,
    input logic                 mem_wr,
    input logic                 ram_cs,
    input logic                 ram_we,
    input logic [RAM_AW-1:0]    ram_addr,
    input logic                 rom_cs,
    input logic                 cmos_cs,
    input logic                 cmos_we,
    input logic [7:0]           io_addr,
    input logic                 io_wr,
    input logic [DATA_W-1:0]    io_wdata,
    input logic                 timer_out,
    input logic                 spk_en,
    input logic                 spk_flag,
    input mode_e                mode,
    input logic [NUM_BANKS-1:0] bank_nib
);
    logic in_common;
    assign in_common = (mem_addr[ADDR_W-1:PAGE_W] > PG_BANK_LAST);

    a_r2_boot_drops_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BOOT && mem_wr && !in_common) |-> (!ram_we && !cmos_we && !rom_cs));

    a_r3_common_area: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && in_common) |-> (ram_cs && ram_addr == RAM_AW'(mem_addr)));

    a_r5_bank0_first: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FULL && ram_cs && !in_common && bank_nib[0])
            |-> (ram_addr[RAM_AW-1:ADDR_W] == '0));

    a_r6_open_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FULL && bank_nib == '0 && !in_common) |-> !ram_cs);

    a_r7_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_cs, rom_cs, cmos_cs}));

    a_r8_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr[7:2] == PORT_STAT) |=> (bank_nib == $past(io_wdata[DATA_W-1 -: NUM_BANKS])));

    a_r12_spk_follow: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (spk_en == $past(spk_flag | timer_out)));
endmodule

bind memmap_ctrl memmap_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr), .rom_cs(rom_cs),
    .cmos_cs(cmos_cs), .cmos_we(cmos_we), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .timer_out(timer_out), .spk_en(spk_en),
    .spk_flag(spk_flag), .mode(mode), .bank_nib(bank_nib)
);

// File: tb/memmap_ctrl_tb.sv
module memmap_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OP_IOW = 2'd0, OP_IOR = 2'd1, OP_MW = 2'd2, OP_MR = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [7:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 58;
    localparam vec_t VECS [NV] = '{
        '{OP_IOR, 16'h0030, 8'h00, 8'h0B, 4'd10}, // R1 R10 reset status
        '{OP_IOR, 16'h0019, 8'h00, 8'hA5, 4'd11}, // R11
        '{OP_MR,  16'h0005, 8'h00, 8'h39, 4'd2 }, // R2 rom
        '{OP_MR,  16'h1FFF, 8'h00, 8'hC3, 4'd2 },
        '{OP_MR,  16'h2000, 8'h00, 8'hFF, 4'd2 },
        '{OP_MW,  16'hE010, 8'h77, 8'h00, 4'd3 },
        '{OP_MR,  16'hE010, 8'h00, 8'h77, 4'd3 }, // R3
        '{OP_IOW, 16'h0030, 8'h10, 8'h00, 4'd8 },
        '{OP_MW,  16'h1000, 8'h11, 8'h00, 4'd2 }, // dropped in boot
        '{OP_MR,  16'h3000, 8'h00, 8'hFF, 4'd2 },
        '{OP_IOW, 16'h0032, 8'h20, 8'h00, 4'd8 },
        '{OP_IOW, 16'h001D, 8'h00, 8'h00, 4'd8 }, // OVERLAY_OFF -> FULL
        '{OP_MW,  16'h1000, 8'hA1, 8'h00, 4'd4 },
        '{OP_MR,  16'h1000, 8'h00, 8'hA1, 4'd4 }, // R4
        '{OP_IOW, 16'h0030, 8'h10, 8'h00, 4'd8 },
        '{OP_MR,  16'h1000, 8'h00, 8'h00, 4'd2 }, // R2 boot write dropped
        '{OP_MW,  16'hD000, 8'h55, 8'h00, 4'd4 },
        '{OP_MR,  16'hE010, 8'h00, 8'h77, 4'd3 },
        '{OP_IOW, 16'h0030, 8'hF0, 8'h00, 4'd5 },
        '{OP_MR,  16'hD000, 8'h00, 8'h55, 4'd5 }, // R5 bit4 wins
        '{OP_IOW, 16'h0030, 8'hE0, 8'h00, 4'd5 },
        '{OP_MR,  16'h1000, 8'h00, 8'hA1, 4'd5 },
        '{OP_IOW, 16'h0030, 8'hC0, 8'h00, 4'd5 },
        '{OP_MR,  16'h1000, 8'h00, 8'h00, 4'd5 },
        '{OP_MW,  16'h1000, 8'hB2, 8'h00, 4'd5 },
        '{OP_IOW, 16'h0030, 8'h80, 8'h00, 4'd5 },
        '{OP_MW,  16'h1000, 8'hC3, 8'h00, 4'd5 },
        '{OP_MR,  16'h1000, 8'h00, 8'hC3, 4'd5 },
        '{OP_IOW, 16'h0030, 8'h40, 8'h00, 4'd5 },
        '{OP_MR,  16'h1000, 8'h00, 8'hB2, 4'd5 },
        '{OP_IOW, 16'h0030, 8'h00, 8'h00, 4'd6 },
        '{OP_MR,  16'h1000, 8'h00, 8'hFF, 4'd6 }, // R6
        '{OP_MW,  16'h1000, 8'hEE, 8'h00, 4'd6 },
        '{OP_MR,  16'hE010, 8'h00, 8'h77, 4'd3 },
        '{OP_IOW, 16'h0030, 8'h20, 8'h00, 4'd8 },
        '{OP_MR,  16'h1000, 8'h00, 8'hA1, 4'd6 }, // R6 write dropped
        '{OP_MW,  16'h8000, 8'h66, 8'h00, 4'd7 },
        '{OP_IOW, 16'h0021, 8'h01, 8'h00, 4'd8 }, // WIN_ON
        '{OP_MW,  16'h8000, 8'h99, 8'h00, 4'd7 },
        '{OP_MR,  16'h8000, 8'h00, 8'h99, 4'd7 }, // R7 cmos
        '{OP_MR,  16'h1000, 8'h00, 8'hA1, 4'd7 },
        '{OP_MW,  16'h8800, 8'h44, 8'h00, 4'd7 },
        '{OP_MW,  16'h87FF, 8'h5C, 8'h00, 4'd7 },
        '{OP_MR,  16'h87FF, 8'h00, 8'h5C, 4'd7 },
        '{OP_IOW, 16'h0020, 8'h00, 8'h00, 4'd8 }, // WIN_OFF
        '{OP_MR,  16'h8000, 8'h00, 8'h66, 4'd7 },
        '{OP_MR,  16'h8800, 8'h00, 8'h44, 4'd7 },
        '{OP_IOW, 16'h0022, 8'h01, 8'h00, 4'd8 },
        '{OP_IOW, 16'h001C, 8'h01, 8'h00, 4'd8 }, // OVERLAY_ON
        '{OP_MR,  16'h0005, 8'h00, 8'h39, 4'd8 }, // R8 boot precedence
        '{OP_MR,  16'h8000, 8'h00, 8'hFF, 4'd8 },
        '{OP_IOR, 16'h0033, 8'h00, 8'h2B, 4'd10},
        '{OP_IOW, 16'h001F, 8'h00, 8'h00, 4'd8 }, // back to WINDOW
        '{OP_MR,  16'h8000, 8'h00, 8'h99, 4'd8 },
        '{OP_IOR, 16'h0040, 8'h00, 8'hFF, 4'd13}, // R13
        '{OP_IOW, 16'h0044, 8'h00, 8'h00, 4'd13},
        '{OP_IOW, 16'h0034, 8'h00, 8'h00, 4'd13},
        '{OP_IOR, 16'h0031, 8'h00, 8'h2B, 4'd13}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr = '0;
    logic [7:0]  mem_wdata = '0;
    logic        mem_rd = 1'b0, mem_wr = 1'b0;
    logic [7:0]  mem_rdata;
    logic [7:0]  io_addr = '0, io_wdata = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0]  io_rdata;
    logic [7:0]  dip_sw = 8'h5A;
    logic        disk_present = 1'b1, motor_on = 1'b0, fdc_irq = 1'b1, timer_out = 1'b0;
    logic        spk_en;
    logic        ram_cs, ram_we, rom_cs, cmos_cs, cmos_we;
    logic [17:0] ram_addr;
    logic [12:0] rom_addr;
    logic [10:0] cmos_addr;
    logic [7:0]  ram_q = '0, rom_q = '0, cmos_q = '0, st_wdata;

    int total = 0;
    int bad = 0;

    logic [7:0] ram_m [int];
    logic [7:0] cmos_m [2048];

    always #(CLK_PERIOD / 2) clk = ~clk;

    memmap_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rd(io_rd), .io_wr(io_wr),
        .io_rdata(io_rdata), .dip_sw(dip_sw), .disk_present(disk_present),
        .motor_on(motor_on), .fdc_irq(fdc_irq), .timer_out(timer_out),
        .spk_en(spk_en), .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_rdata(ram_q), .rom_cs(rom_cs), .rom_addr(rom_addr), .rom_rdata(rom_q),
        .cmos_cs(cmos_cs), .cmos_we(cmos_we), .cmos_addr(cmos_addr),
        .cmos_rdata(cmos_q), .st_wdata(st_wdata)
    );

    // behavioural synchronous-read stores
    always @(posedge clk) begin
        if (ram_cs) begin
            if (ram_we) ram_m[int'(ram_addr)] = st_wdata;
            else        ram_q <= ram_m.exists(int'(ram_addr)) ? ram_m[int'(ram_addr)] : 8'h00;
        end
        if (rom_cs) rom_q <= rom_addr[7:0] ^ 8'h3C;
        if (cmos_cs) begin
            if (cmos_we) cmos_m[cmos_addr] = st_wdata;
            else         cmos_q <= cmos_m[cmos_addr];
        end
    end

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, got, exp);
        end
    endtask

    // one access; read result sampled at the falling edge after the strobe edge (R9)
    task automatic do_op(input logic [1:0] op, input logic [15:0] a,
                         input logic [7:0] d, output logic [7:0] got);
        mem_addr = a; io_addr = a[7:0]; mem_wdata = d; io_wdata = d;
        mem_rd = (op == OP_MR); mem_wr = (op == OP_MW);
        io_rd  = (op == OP_IOR); io_wr  = (op == OP_IOW);
        @(posedge clk);
        @(negedge clk);
        mem_rd = 1'b0; mem_wr = 1'b0; io_rd = 1'b0; io_wr = 1'b0;
        got = (op == OP_IOR) ? io_rdata : mem_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] g;
        for (int i = 0; i < 2048; i++) cmos_m[i] = 8'h00;
        repeat (3) @(negedge clk);
        check("R1", {7'd0, spk_en}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            do_op(VECS[i].op, VECS[i].addr, VECS[i].data, g);
            if (VECS[i].op == OP_MR || VECS[i].op == OP_IOR)
                check($sformatf("R%0d vec%0d", VECS[i].req, i), g, VECS[i].exp);
        end

        // R10: live sideband lines
        motor_on = 1'b1; fdc_irq = 1'b0; disk_present = 1'b1;
        do_op(OP_IOR, 16'h0030, 8'h00, g);
        check("R10 sideband", g, 8'h28);
        disk_present = 1'b0; motor_on = 1'b0;
        do_op(OP_IOR, 16'h0032, 8'h00, g);
        check("R10 sideband", g, 8'h22);
        dip_sw = 8'h0F;
        do_op(OP_IOR, 16'h001A, 8'h00, g);
        check("R11 dip", g, 8'hF0);

        // R9: read data appears exactly one cycle after the strobe
        do_op(OP_MR, 16'hE010, 8'h00, g);
        check("R9 latency", mem_rdata, 8'h77);
        @(negedge clk);
        check("R9 idle returns open", mem_rdata, 8'hFF);

        // R12: speaker flag and timer
        do_op(OP_IOW, 16'h0018, 8'h04, g);
        check("R12 spk lag", {7'd0, spk_en}, 8'h00);
        @(negedge clk);
        check("R12 spk on", {7'd0, spk_en}, 8'h01);
        do_op(OP_IOW, 16'h001B, 8'hFB, g);
        @(negedge clk);
        check("R12 spk off by bit2", {7'd0, spk_en}, 8'h00);
        timer_out = 1'b1;
        @(negedge clk);
        check("R12 timer", {7'd0, spk_en}, 8'h01);
        timer_out = 1'b0;
        @(negedge clk);
        check("R12 timer off", {7'd0, spk_en}, 8'h00);
        do_op(OP_IOW, 16'h0019, 8'h04, g);

        // R1: reset mid-run restores boot mode and clears registers
        disk_present = 1'b1; fdc_irq = 1'b1;
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R1 spk in reset", {7'd0, spk_en}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        do_op(OP_IOR, 16'h0030, 8'h00, g);
        check("R1 bank cleared", g, 8'h0B);
        do_op(OP_MR, 16'h0005, 8'h00, g);
        check("R1 boot rom", g, 8'h39);
        do_op(OP_IOW, 16'h001C, 8'h00, g);
        do_op(OP_IOW, 16'h0030, 8'h20, g);
        do_op(OP_MR, 16'h8000, 8'h00, g);
        check("R1 window flag cleared", g, 8'h66);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule